// File: doc/BRIEF.md
# Automatic Range Selection Sequencer

This block decides which full-scale range an integrating light-to-digital converter uses for each measurement. A 4-bit range request selects either a fixed manual range or automatic ranging. The block then launches the converter at the chosen range and watches the converter's overload indication. It reports the exponent of the finished measurement together with an overflow flag.

In automatic mode, an overload seen while the range is below the top one cancels the conversion in flight. The range steps up by one and a fresh conversion starts straight away. This repeats until a conversion finishes without overload or the top range is in use. Only at that point is the overflow flag written, so it reports light beyond the whole device's span. In manual mode, the flag records any overload seen during the conversion window, a short spike included, even if the final reading is below full scale. A mask option zeroes the reported exponent for manual measurements. A separate unmasked exponent output stays available for limit comparison.

Top module: `ars_seq`

## Requirements
- R1: After reset, `busy`, `conv_start`, `res_valid`, `ovf_flag`, `res_exp` and `res_exp_raw` are all 0, and the automatic start range is 0000b.
- R2: A request with `cfg_range` from 0000b to 1011b converts at exactly that range. It issues one `conv_start` and never climbs, even on overload. `res_exp_raw` equals the code.
- R3: `cfg_range` 1100b selects automatic mode. With default parameters, the codes 1101b, 1110b and 1111b also select automatic mode.
- R4: In automatic mode, `conv_ovf` high during a conversion at a range below 1011b starts a new conversion in the next cycle at range+1, with a one-cycle `conv_start` pulse. That overload does not count toward the flag.
- R5: An automatic climb stops at the first conversion that completes, or at range 1011b. `conv_range` never exceeds 1011b.
- R6: In automatic mode, `ovf_flag` is 1 only when overload was seen at range 1011b.
- R7: In manual mode, `ovf_flag` is 1 when `conv_ovf` was high in any cycle of the conversion window, including a transient that is gone by `conv_done`.
- R8: `ovf_flag` is re-evaluated at the end of every measurement and cleared when that measurement saw no counted overload.
- R9: Each automatic measurement starts at the range on which the previous automatic climb settled. The range never decreases during a measurement.
- R10: With `cfg_mask_exp` = 1, a manual result reports `res_exp` = 0000b while `res_exp_raw` keeps the range. The mask has no effect on automatic results.
- R11: `meas_req` while `busy` is 1 is ignored: it causes no extra `conv_start`.
- R12: `res_valid` pulses for one cycle, one clock after `conv_done` is sampled. The result outputs hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_range | input | RW | Range request: manual code or automatic |
| cfg_mask_exp | input | 1 | Zero the reported exponent for manual results |
| meas_req | input | 1 | Start one measurement when idle |
| conv_ovf | input | 1 | Converter overload indication, level |
| conv_done | input | 1 | Converter end-of-conversion strobe |
| conv_start | output | 1 | One-cycle strobe that (re)starts the converter |
| conv_range | output | RW | Range driven to the converter |
| busy | output | 1 | A measurement is in progress |
| res_valid | output | 1 | One-cycle strobe: a result was committed |
| res_exp | output | RW | Reported exponent, masked as configured |
| res_exp_raw | output | RW | Unmasked exponent for limit compare |
| ovf_flag | output | 1 | Overflow flag of the last measurement |

## Verification
Light levels are drawn below, at and above the current settled range, as well as beyond the top range. Comparing these separates a single-step climb from a multi-step climb and from a capped climb. Counting `conv_start` pulses per measurement shows whether the climb restarted once per step, and whether it began from the previously settled range. Manual requests with a short overload spike and a steady reading below full scale show that the flag keeps transients. Random interleaving of manual, automatic and reserved codes with the mask toggled shows that masking touches only manual results. A request sent in the middle of a conversion shows that it is dropped.

// File: rtl/ars_pkg.sv
package ars_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } ars_state_e;
endpackage

// File: rtl/ars_mode_dec.sv
module ars_mode_dec #(
   parameter int RW           = 4,
   parameter int MAX_CODE     = 11,
   parameter int AUTO_CODE    = 12,
   parameter bit RESV_AS_AUTO = 1'b1
) (
   input  logic [RW-1:0] cfg_range,
   output logic          is_auto,
   output logic [RW-1:0] man_range
);
   localparam logic [RW-1:0] MAXV  = RW'(MAX_CODE);
   localparam logic [RW-1:0] AUTOV = RW'(AUTO_CODE);

   generate
      if (RESV_AS_AUTO) begin : g_resv_auto
         always_comb begin
            is_auto   = (cfg_range >= AUTOV);
            man_range = cfg_range;
         end
      end else begin : g_resv_clamp
         always_comb begin
            is_auto   = (cfg_range == AUTOV);
            man_range = (cfg_range > MAXV) ? MAXV : cfg_range;
         end
      end
   endgenerate
endmodule

// File: rtl/ars_climb.sv
module ars_climb
   import ars_pkg::*;
#(
   parameter int RW       = 4,
   parameter int MAX_CODE = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          meas_req,
   input  logic          is_auto,
   input  logic [RW-1:0] man_range,
   input  logic          conv_ovf,
   input  logic          conv_done,
   output logic          busy,
   output logic          conv_start,
   output logic [RW-1:0] conv_range,
   output logic          launch,
   output logic          restart,
   output logic          commit,
   output logic          run_auto
);
   localparam logic [RW-1:0] MAXV = RW'(MAX_CODE);
   localparam logic [RW-1:0] ONE  = RW'(1);

   ars_state_e    state;
   logic [RW-1:0] run_range;
   logic [RW-1:0] settled;

   always_comb begin
      busy    = (state == ST_RUN);
      launch  = !busy && meas_req;
      restart = busy && run_auto && conv_ovf && (run_range < MAXV);
      commit  = busy && conv_done && !restart;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         run_range  <= '0;
         settled    <= '0;
         run_auto   <= 1'b0;
         conv_start <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         if (launch) begin
            state      <= ST_RUN;
            run_auto   <= is_auto;
            run_range  <= is_auto ? settled : man_range;
            conv_start <= 1'b1;
         end else if (restart) begin
            run_range  <= run_range + ONE;
            settled    <= run_range + ONE;
            conv_start <= 1'b1;
         end else if (commit) begin
            state <= ST_IDLE;
         end
      end
   end

   assign conv_range = run_range;

   p_climb_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && run_auto && conv_ovf && conv_range < MAXV)
      |=> (conv_start && conv_range == $past(conv_range) + ONE));

   p_range_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_range <= MAXV);

   p_no_lower_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(conv_start) && !conv_start)
      |-> conv_range >= $past(conv_range));

   p_req_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && meas_req && !conv_ovf) |=> !conv_start);
endmodule

// File: rtl/ars_ovf_track.sv
module ars_ovf_track (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic launch,
   input  logic restart,
   input  logic commit,
   input  logic conv_ovf,
   output logic ovf_flag
);
   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         if (launch || restart) seen <= 1'b0;
         else if (busy && conv_ovf) seen <= 1'b1;
         if (commit) ovf_flag <= seen || conv_ovf;
      end
   end

   p_flag_only_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(commit) |-> $stable(ovf_flag));
endmodule

// File: rtl/ars_report.sv
module ars_report #(
   parameter int RW       = 4,
   parameter int MAX_CODE = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic          run_auto,
   input  logic          cfg_mask_exp,
   input  logic [RW-1:0] conv_range,
   output logic          res_valid,
   output logic [RW-1:0] res_exp,
   output logic [RW-1:0] res_exp_raw,
   output logic          res_auto
);
   localparam logic [RW-1:0] MAXV = RW'(MAX_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_exp     <= '0;
         res_exp_raw <= '0;
         res_auto    <= 1'b0;
      end else begin
         res_valid <= commit;
         if (commit) begin
            res_exp_raw <= conv_range;
            res_exp     <= (cfg_mask_exp && !run_auto) ? '0 : conv_range;
            res_auto    <= run_auto;
         end
      end
   end

   p_valid_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_auto_unmasked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_auto) |-> res_exp == res_exp_raw);

   p_raw_in_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_exp_raw <= MAXV);
endmodule

// File: rtl/ars_seq.sv
module ars_seq #(
   parameter int RW           = 4,
   parameter int MAX_CODE     = 11,
   parameter int AUTO_CODE    = 12,
   parameter bit RESV_AS_AUTO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] cfg_range,
   input  logic          cfg_mask_exp,
   input  logic          meas_req,
   input  logic          conv_ovf,
   input  logic          conv_done,
   output logic          conv_start,
   output logic [RW-1:0] conv_range,
   output logic          busy,
   output logic          res_valid,
   output logic [RW-1:0] res_exp,
   output logic [RW-1:0] res_exp_raw,
   output logic          ovf_flag
);
   localparam logic [RW-1:0] MAXV = RW'(MAX_CODE);

   generate
      if (MAX_CODE >= AUTO_CODE) begin : g_bad_order
         initial $fatal(1, "ars_seq: MAX_CODE must lie below AUTO_CODE");
      end
      if (AUTO_CODE > (1 << RW) - 1) begin : g_bad_width
         initial $fatal(1, "ars_seq: AUTO_CODE does not fit in RW bits");
      end
   endgenerate

   logic          is_auto, launch, restart, commit, run_auto, res_auto;
   logic [RW-1:0] man_range;

   ars_mode_dec #(.RW(RW), .MAX_CODE(MAX_CODE), .AUTO_CODE(AUTO_CODE),
                  .RESV_AS_AUTO(RESV_AS_AUTO)) u_dec (
      .cfg_range (cfg_range),
      .is_auto   (is_auto),
      .man_range (man_range)
   );

   ars_climb #(.RW(RW), .MAX_CODE(MAX_CODE)) u_climb (
      .clk        (clk),
      .rst_n      (rst_n),
      .meas_req   (meas_req),
      .is_auto    (is_auto),
      .man_range  (man_range),
      .conv_ovf   (conv_ovf),
      .conv_done  (conv_done),
      .busy       (busy),
      .conv_start (conv_start),
      .conv_range (conv_range),
      .launch     (launch),
      .restart    (restart),
      .commit     (commit),
      .run_auto   (run_auto)
   );

   ars_ovf_track u_ovf (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy     (busy),
      .launch   (launch),
      .restart  (restart),
      .commit   (commit),
      .conv_ovf (conv_ovf),
      .ovf_flag (ovf_flag)
   );

   ars_report #(.RW(RW), .MAX_CODE(MAX_CODE)) u_rep (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit       (commit),
      .run_auto     (run_auto),
      .cfg_mask_exp (cfg_mask_exp),
      .conv_range   (conv_range),
      .res_valid    (res_valid),
      .res_exp      (res_exp),
      .res_exp_raw  (res_exp_raw),
      .res_auto     (res_auto)
   );

   p_auto_flag_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_auto && ovf_flag) |-> res_exp_raw == MAXV);

   p_manual_no_climb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !run_auto && !conv_start) |=> !conv_start);
endmodule

// File: tb/tb_ars_seq.sv
module tb_ars_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cfg_range = 4'd12;
   logic       cfg_mask_exp = 1'b0;
   logic       meas_req = 1'b0;
   logic       conv_ovf = 1'b0;
   logic       conv_done = 1'b0;
   logic       conv_start, busy, res_valid, ovf_flag;
   logic [3:0] conv_range, res_exp, res_exp_raw;

   int n_chk = 0, n_bad = 0, cycles = 0;
   bit finished = 0;
   int light = 0;
   bit spike = 0;
   int cnt = 0;
   bit active = 0;
   int starts = 0;
   int tb_settled = 0;

   always #10 clk = ~clk;

   ars_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_range(cfg_range), .cfg_mask_exp(cfg_mask_exp),
      .meas_req(meas_req), .conv_ovf(conv_ovf), .conv_done(conv_done),
      .conv_start(conv_start), .conv_range(conv_range), .busy(busy),
      .res_valid(res_valid), .res_exp(res_exp), .res_exp_raw(res_exp_raw),
      .ovf_flag(ovf_flag)
   );

   // behavioural converter: overload checked at step 2 and at completion (step 5)
   always @(negedge clk) begin
      conv_ovf  <= 1'b0;
      conv_done <= 1'b0;
      if (conv_start) begin
         starts <= starts + 1;
         cnt    <= 1;
         active <= 1'b1;
      end else if (active) begin
         cnt <= cnt + 1;
         if (cnt + 1 == 2)
            conv_ovf <= (light > int'(conv_range)) || spike;
         if (cnt + 1 == 5) begin
            conv_ovf  <= (light > int'(conv_range));
            conv_done <= 1'b1;
            active    <= 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit is_auto_code(int code);
      return code >= 12;
   endfunction

   function automatic int exp_range(int code, int lt, int settled);
      if (!is_auto_code(code)) return code;
      if (lt > settled) return (lt > 11) ? 11 : lt;
      return settled;
   endfunction

   task automatic measure(int code, bit mask, int lt, bit spk, bit mid_req);
      int er, eo, ee, es, wait_n;
      int s0;
      @(negedge clk);
      cfg_range = 4'(code); cfg_mask_exp = mask; light = lt; spike = spk;
      s0 = starts;
      meas_req = 1'b1;
      @(negedge clk);
      meas_req = 1'b0;
      if (mid_req) begin
         @(negedge clk);
         meas_req = 1'b1;
         @(negedge clk);
         meas_req = 1'b0;
      end
      wait_n = 0;
      while (!res_valid && wait_n < 300) begin
         @(negedge clk);
         wait_n++;
      end
      er = exp_range(code, lt, tb_settled);
      if (is_auto_code(code)) begin
         es = 1 + er - tb_settled;
         eo = (lt > 11) ? 1 : 0;
         ee = er;
         tb_settled = er;
      end else begin
         es = 1;
         eo = (lt > code || spk) ? 1 : 0;
         ee = mask ? 0 : code;
      end
      chk("R12 res_valid seen", int'(res_valid), 1);
      chk(is_auto_code(code) ? "R5 raw exp auto" : "R2 raw exp manual", int'(res_exp_raw), er);
      chk(mask ? "R10 masked exp" : "R3 exp", int'(res_exp), ee);
      chk(is_auto_code(code) ? "R6 auto ovf flag" : "R7 manual ovf flag", int'(ovf_flag), eo);
      chk(mid_req ? "R11 starts" : "R4 R9 starts", starts - s0, es);
      @(negedge clk);
      chk("R12 valid one cycle", int'(res_valid), 0);
      chk("R12 result held", int'(res_exp_raw), er);
      spike = 0;
   endtask

   initial begin
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 conv_start", int'(conv_start), 0);
      chk("R1 res_valid", int'(res_valid), 0);
      chk("R1 ovf_flag", int'(ovf_flag), 0);
      chk("R1 res_exp", int'(res_exp), 0);
      chk("R1 res_exp_raw", int'(res_exp_raw), 0);
      rst_n = 1'b1;
      // R1: auto start range 0, dim light: settles at 0
      measure(12, 0, 0, 0, 0);
      // R4 single step, R5 multi-step climb
      measure(12, 0, 1, 0, 0);
      measure(12, 0, 6, 0, 0);
      // R9 brighter then dimmer: no lowering
      measure(12, 0, 2, 0, 0);
      // R6 beyond top, then exactly top
      measure(12, 0, 13, 0, 0);
      measure(12, 0, 11, 0, 0);
      // R8 flag cleared on next clean measurement
      chk("R8 flag cleared", int'(ovf_flag), 0);
      // R3 reserved codes act as automatic
      measure(13, 0, 3, 0, 0);
      measure(15, 1, 12, 0, 0);
      // R2 manual with overload: no climb; R7 transient spike
      measure(3, 0, 9, 0, 0);
      measure(7, 0, 2, 1, 0);
      measure(7, 0, 2, 0, 0);
      // R10 mask on manual
      measure(5, 1, 4, 0, 0);
      // R11 request while busy dropped
      measure(4, 0, 1, 0, 1);
      // random mix
      for (int i = 0; i < 150; i++) begin
         int sel, code, lt;
         bit mk, sp;
         sel  = $urandom_range(0, 2);
         code = (sel == 0) ? int'($urandom_range(12, 15)) : int'($urandom_range(0, 11));
         lt   = $urandom_range(0, 13);
         mk   = 1'($urandom_range(0, 1));
         sp   = (code < 12) ? 1'($urandom_range(0, 1)) : 1'b0;
         measure(code, mk, lt, sp, 1'($urandom_range(0, 7) == 0));
      end
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule